// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks one vector operation through its elements, one element per clock, from index 0 up to VL-1. For each element it produces the destination register number, the element index and an eight-bit byte write-enable vector for a 64-bit register file write port. Elements are packed from the least significant byte of the base register upward. When a register is full, the next element goes into the next higher-numbered register. The element width is chosen by a 2-bit code, so one register holds 1, 2, 4 or 8 elements.

Each element also gets a predicate bit, taken from one of three 64-bit integer mask registers under a 3-bit mask mode. The predicate bit is widened into byte write enables that cover exactly the element's bytes. The mask value is captured when the operation starts. A surrounding datapath uses the per-element strobe to perform the arithmetic and write the result lanes. It uses the done pulse to retire the operation.

Top module: `vec_elem_seq`

## Requirements
- R1: The width code sets the element size in bytes: 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2 and 2'b11 gives 1, which is 8 >> code.
- R2: Let W be the element size in bytes. Element i lives in register `base_reg + (i*W)/8` at byte offset `(i*W) mod 8`, so numbering starts at byte 0 and spills into higher registers.
- R3: A start with `vl` = 0 issues no element and drives no byte enable. `done` is high for exactly the one following cycle.
- R4: Mask mode 3'b000 enables every element. Mode 3'b001 enables only the element whose index equals the full 64-bit value of `mask_r3`.
- R5: Modes 3'b010 and 3'b011 enable element i when bit i of `mask_r3` is 1 or 0 respectively. Modes 3'b100/3'b101 do the same with `mask_r10`, and 3'b110/3'b111 with `mask_r30`. For indices of 64 and above, the tested bit reads as 0.
- R6: An enabled element drives W adjacent byte enables, starting at its byte offset, and no others.
- R7: A disabled element still takes its cycle with `elem_valid` high, but all of its byte enables are 0.
- R8: The selected mask register is sampled on the start cycle. Later changes on the mask inputs do not affect the running operation.
- R9: Element i is presented i+1 cycles after the accepted start, with `elem_idx` = i. `done` is high for one cycle, in the cycle right after element VL-1, while `elem_valid` is low.
- R10: A start pulse that arrives while elements are still being issued is ignored, and the running sequence continues unchanged.
- R11: Register numbers wrap modulo 128 past register 127.
- R12: After reset, `elem_valid`, `done` and all byte enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| vl | input | 7 | Number of elements |
| base_reg | input | 7 | First destination register |
| ew_code | input | 2 | Element width code |
| mask_mode | input | 3 | Predicate source and sense |
| mask_r3 | input | 64 | Integer mask register A |
| mask_r10 | input | 64 | Integer mask register B |
| mask_r30 | input | 64 | Integer mask register C |
| elem_valid | output | 1 | An element is presented this cycle |
| elem_reg | output | 7 | Register holding the element |
| elem_byte_en | output | 8 | Byte write enables for the register |
| elem_idx | output | 7 | Element index |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each element width is run with a sequence long enough to cross at least one register boundary. This separates a correct spill-over from a wrong offset or shift. Every mask mode is applied to irregular bit patterns, so set-sense and clear-sense can be told apart, and the three mask registers cannot be swapped without notice. The index-equality mode is also run. Further runs cover a zero-length start, a 127-element 8-bit run that wraps the register number and reads mask indices past 63, a start during a running operation, and mask inputs scrambled right after the start. These runs show whether the design captures its operands or keeps reading the live inputs.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int REG_BYTES = 8;
    localparam int OFF_W     = 3;

    typedef enum logic [1:0] {
        EW_FULL = 2'b00,
        EW_32   = 2'b01,
        EW_16   = 2'b10,
        EW_8    = 2'b11
    } ew_e;

    typedef enum logic [2:0] {
        PM_ALL     = 3'b000,
        PM_ONE     = 3'b001,
        PM_A_SET   = 3'b010,
        PM_A_CLR   = 3'b011,
        PM_B_SET   = 3'b100,
        PM_B_CLR   = 3'b101,
        PM_C_SET   = 3'b110,
        PM_C_CLR   = 3'b111
    } pmode_e;
endpackage

// File: rtl/vseq_pred.sv
module vseq_pred #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 7
) (
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] src,
    input  logic [IDX_W-1:0]  idx,
    output logic              pred
);
    localparam int SEL_W = $clog2(DATA_W);

    logic in_range;
    logic bit_hit;

    always_comb begin
        in_range = (32'(idx) < DATA_W);
        bit_hit  = in_range ? src[idx[SEL_W-1:0]] : 1'b0;
        case (mode)
            vseq_pkg::PM_ALL: pred = 1'b1;
            vseq_pkg::PM_ONE: pred = (src == DATA_W'(idx));
            default:          pred = bit_hit ^ mode[0];
        endcase
    end
endmodule

// File: rtl/vseq_place.sv
module vseq_place #(
    parameter int IDX_W  = 7,
    parameter int RIDX_W = 7,
    parameter int OFF_W  = 3
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [RIDX_W-1:0] base,
    input  logic [1:0]        ew,
    output logic [RIDX_W-1:0] reg_o,
    output logic [OFF_W-1:0]  off_o
);
    localparam int POS_W = IDX_W + OFF_W;

    logic [1:0]       shamt;
    logic [POS_W-1:0] pos;

    always_comb begin
        shamt = 2'd3 - ew;
        pos   = POS_W'(idx) << shamt;
        reg_o = base + RIDX_W'(pos >> OFF_W);
        off_o = pos[OFF_W-1:0];
    end
endmodule

// File: rtl/vseq_byte_en.sv
module vseq_byte_en #(
    parameter int NBYTES = 8,
    parameter int OFF_W  = 3
) (
    input  logic              pred,
    input  logic [1:0]        ew,
    input  logic [OFF_W-1:0]  off,
    output logic [NBYTES-1:0] be
);
    logic [OFF_W:0] wbytes;

    assign wbytes = (OFF_W + 1)'(NBYTES >> ew);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign be[b] = pred && (32'(b) >= 32'(off)) &&
                       (32'(b) < 32'(off) + 32'(wbytes));
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 7,
    parameter int RIDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  vl,
    input  logic [RIDX_W-1:0] base_reg,
    input  logic [1:0]        ew_code,
    input  logic [2:0]        mask_mode,
    input  logic [DATA_W-1:0] mask_r3,
    input  logic [DATA_W-1:0] mask_r10,
    input  logic [DATA_W-1:0] mask_r30,
    output logic              elem_valid,
    output logic [RIDX_W-1:0] elem_reg,
    output logic [DATA_W/8-1:0] elem_byte_en,
    output logic [IDX_W-1:0]  elem_idx,
    output logic              done
);
    localparam int NBYTES = DATA_W / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  vl;
        logic [RIDX_W-1:0] base;
        logic [1:0]        ew;
        logic [2:0]        mode;
        logic [DATA_W-1:0] src;
    } st_t;

    st_t st_d, st_q;

    logic              pred;
    logic [OFF_W-1:0]  off;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.idx == st_q.vl - IDX_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end else if (start) begin
            st_d.idx  = '0;
            st_d.vl   = vl;
            st_d.base = base_reg;
            st_d.ew   = ew_code;
            st_d.mode = mask_mode;
            case (mask_mode[2:1])
                2'b10:   st_d.src = mask_r10;
                2'b11:   st_d.src = mask_r30;
                default: st_d.src = mask_r3;
            endcase
            if (vl == '0) st_d.done = 1'b1;
            else          st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    vseq_pred #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pred (
        .mode (st_q.mode),
        .src  (st_q.src),
        .idx  (st_q.idx),
        .pred (pred)
    );

    vseq_place #(.IDX_W(IDX_W), .RIDX_W(RIDX_W), .OFF_W(OFF_W)) u_place (
        .idx   (st_q.idx),
        .base  (st_q.base),
        .ew    (st_q.ew),
        .reg_o (elem_reg),
        .off_o (off)
    );

    vseq_byte_en #(.NBYTES(NBYTES), .OFF_W(OFF_W)) u_be (
        .pred (pred && st_q.busy),
        .ew   (st_q.ew),
        .off  (off),
        .be   (elem_byte_en)
    );

    assign elem_valid = st_q.busy;
    assign elem_idx   = st_q.idx;
    assign done       = st_q.done;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
    parameter int IDX_W  = 7,
    parameter int RIDX_W = 7,
    parameter int NBYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              elem_valid,
    input logic [RIDX_W-1:0] elem_reg,
    input logic [NBYTES-1:0] elem_byte_en,
    input logic [IDX_W-1:0]  elem_idx,
    input logic              done
);
    assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_valid |-> elem_byte_en == '0);

    assert_lane_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> ($countones(elem_byte_en) == 0 || $countones(elem_byte_en) == 1 ||
                        $countones(elem_byte_en) == 2 || $countones(elem_byte_en) == 4 ||
                        $countones(elem_byte_en) == 8));

    assert_first_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(elem_valid) |-> elem_idx == '0);

    assert_index_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && $past(elem_valid) |-> elem_idx == $past(elem_idx) + IDX_W'(1));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(elem_valid) |-> done);

    assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !elem_valid);

    assert_reg_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid && $past(elem_valid) |->
            (elem_reg == $past(elem_reg) || elem_reg == $past(elem_reg) + RIDX_W'(1)));
endmodule

bind vec_elem_seq vseq_checker #(
    .IDX_W (IDX_W),
    .RIDX_W(RIDX_W),
    .NBYTES(DATA_W / 8)
) u_vseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .elem_valid  (elem_valid),
    .elem_reg    (elem_reg),
    .elem_byte_en(elem_byte_en),
    .elem_idx    (elem_idx),
    .done        (done)
);

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [6:0]  vl;
    logic [6:0]  base_reg;
    logic [1:0]  ew_code;
    logic [2:0]  mask_mode;
    logic [63:0] mask_r3, mask_r10, mask_r30;
    logic        elem_valid;
    logic [6:0]  elem_reg;
    logic [7:0]  elem_byte_en;
    logic [6:0]  elem_idx;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    vec_elem_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .base_reg(base_reg),
        .ew_code(ew_code), .mask_mode(mask_mode), .mask_r3(mask_r3),
        .mask_r10(mask_r10), .mask_r30(mask_r30), .elem_valid(elem_valid),
        .elem_reg(elem_reg), .elem_byte_en(elem_byte_en), .elem_idx(elem_idx),
        .done(done)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_pred(int i, int mode, logic [63:0] a, logic [63:0] b,
                                    logic [63:0] c);
        logic [63:0] s;
        bit          hit;
        case (mode >> 1)
            2:       s = b;
            3:       s = c;
            default: s = a;
        endcase
        hit = (i < 64) ? s[i] : 1'b0;
        if (mode == 0) return 1'b1;
        if (mode == 1) return a == 64'(i);
        return ((mode & 1) != 0) ? !hit : hit;
    endfunction

    task automatic run_op(int vlv, int basev, int ewv, int mode,
                          logic [63:0] a, logic [63:0] b, logic [63:0] c, bit disturb);
        int w;
        @(negedge clk);
        vl = 7'(vlv); base_reg = 7'(basev); ew_code = 2'(ewv); mask_mode = 3'(mode);
        mask_r3 = a; mask_r10 = b; mask_r30 = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mask_r3 = ~a; mask_r10 = ~b; mask_r30 = ~c;   // R8: live inputs scrambled
        w = 8 >> ewv;                                   // R1
        if (vlv == 0) begin
            chk("R3", "valid", elem_valid, 0);
            chk("R3", "byte_en", elem_byte_en, 0);
            chk("R3", "done", done, 1);
            @(negedge clk);
            chk("R3", "done drop", done, 0);
            return;
        end
        for (int i = 0; i < vlv; i++) begin
            int  pos = i * w;
            bit  p   = ref_pred(i, mode, a, b, c);
            int  exp_be = p ? (((1 << w) - 1) << (pos % 8)) & 8'hFF : 0;
            if (disturb && i == 1) start = 1'b0;
            chk("R9", "valid", elem_valid, 1);
            chk("R9", "idx", elem_idx, i);
            chk("R2_R11", "reg", elem_reg, (basev + pos / 8) % 128);
            chk(p ? "R6" : "R7", "byte_en", elem_byte_en, exp_be);
            chk("R9", "done low", done, 0);
            if (disturb && i == 0) begin
                start = 1'b1;                             // R10: ignored while busy
                vl = 7'd3; base_reg = 7'd77; ew_code = 2'd0; mask_mode = 3'd0;
            end
            @(negedge clk);
        end
        chk("R9", "done", done, 1);
        chk("R9", "valid after", elem_valid, 0);
        @(negedge clk);
        chk("R9", "done pulse", done, 0);
        chk("R10", "no restart", elem_valid, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<200000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; vl = '0; base_reg = '0; ew_code = '0;
        mask_mode = '0; mask_r3 = '0; mask_r10 = '0; mask_r30 = '0;
        repeat (3) @(negedge clk);
        chk("R12", "valid", elem_valid, 0);
        chk("R12", "done", done, 0);
        chk("R12", "byte_en", elem_byte_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "idle valid", elem_valid, 0);

        run_op(4, 5, 0, 0, 64'h0, 64'h0, 64'h0, 1'b0);                    // R1 R4 full width
        run_op(20, 10, 3, 2, 64'h0000_0000_00A5_3C96, 64'h0, 64'h0, 1'b0); // R5 byte width
        run_op(9, 3, 2, 3, 64'h0000_0000_0000_0136, 64'h0, 64'h0, 1'b0);  // R5 clear sense
        run_op(8, 40, 1, 1, 64'd5, 64'hFF, 64'hFF, 1'b0);                  // R4 single index
        run_op(12, 2, 2, 4, 64'hFFFF, 64'h0000_0000_0000_0A5B, 64'h0, 1'b0);
        run_op(10, 6, 1, 5, 64'h0, 64'h0000_0000_0000_02C9, 64'h0, 1'b0);
        run_op(0, 9, 0, 0, 64'h0, 64'h0, 64'h0, 1'b0);                     // R3
        run_op(127, 120, 3, 6, 64'h0, 64'h0, 64'h8000_0000_F0F0_1234, 1'b0); // R11 R5
        run_op(11, 126, 0, 7, 64'h0, 64'h0, 64'h0000_0000_0000_0529, 1'b1);  // R10 R11
        run_op(6, 0, 1, 1, 64'd70, 64'h0, 64'h0, 1'b0);                      // R4 no hit

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule